// File: doc/BRIEF.md
# Bank-Segmented CAM-Tag Unified Cache

This block holds the tags and data of a 4 KB cache shared by instructions and data. The cache has 256 lines of four 32-bit words. Its tags are kept in a content-addressable store that is split into four banks of 64 entries. Two address bits pick the bank, so each lookup compares against only 64 tags and the other three banks are never enabled. In effect the cache is 64-way set-associative with four sets.

A core request carries an address, a read/write flag, write data and byte enables. One cycle later the block returns a hit flag with the read data. On a read miss it raises an allocation flag that tells the surrounding sequencer to fetch the line. Every write is copied, one cycle later, to a write-through output. A write that hits also merges its enabled bytes into the cached word, and a write miss allocates nothing. The fetched line comes back over a fill port, one word per beat, word 0 first. The first beat claims a victim entry in the target bank: the lowest-numbered invalid entry if one exists, otherwise a pseudo-random one. The line becomes valid only after its last word is written.

Top module: `segcam_cache`

## Requirements
- R1: Address fields: bits [1:0] pick a byte and are ignored on lookup, bits [3:2] pick the word within the line, bits [5:4] pick the tag bank, and bits [31:6] are the tag.
- R2: While `req_valid` is high, `bank_cmp_en` has exactly one bit set, at the position given by address bits [5:4]. While `req_valid` is low, `bank_cmp_en` is zero.
- R3: A read that hits returns `resp_valid=1`, `resp_hit=1` and the stored word on `resp_rdata` in the cycle after the request.
- R4: A read that misses returns `resp_hit=0` and `resp_alloc=1` in the cycle after the request. After reset no line is valid.
- R5: Every write appears on `mem_wr_valid/addr/data/be` in the cycle after the request, whether it hits or misses. A write never raises `resp_alloc`, and a write miss leaves the line uncached.
- R6: A write hit updates only the bytes whose `req_be` bit is set (bit i covers data bits 8i+7..8i). The other bytes keep their old value.
- R7: A fill beat with `fill_word=0` starts a line, and beats 1 to 3 continue it. The line hits only after beat 3 has been written. A lookup in the same cycle as beat 3 still misses.
- R8: The victim is the lowest invalid entry of the bank. When the bank is full, one pseudo-random entry (chosen by a free-running 6-bit LFSR) is replaced and the other 63 stay resident.
- R9: A `flush` pulse invalidates every line and abandons any fill in progress. Later beats of the abandoned fill do not make the line valid.
- R10: A write hit to one line and a fill beat to another line in the same cycle both take effect.
- R11: All four banks together hold 256 distinct lines at once, each returning its own four words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Invalidate all lines |
| req_valid | input | 1 | Core request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| bank_cmp_en | output | 4 | Compare enable per tag bank |
| resp_valid | output | 1 | Response for last cycle's request |
| resp_hit | output | 1 | Lookup hit |
| resp_alloc | output | 1 | Read miss, line fetch needed |
| resp_rdata | output | 32 | Read data on hit, else zero |
| mem_wr_valid | output | 1 | Write-through copy valid |
| mem_wr_addr | output | 32 | Write-through address |
| mem_wr_data | output | 32 | Write-through data |
| mem_wr_be | output | 4 | Write-through byte enables |
| fill_valid | input | 1 | Fill beat present |
| fill_line | input | 28 | Line address (address bits 31:4) |
| fill_word | input | 2 | Word index of the beat |
| fill_data | input | 32 | Fill word |

## Verification
A lookup and a fill can happen in the same cycle. The bench provokes this in two ways. First, it issues a read of a line together with that line's final fill beat, and expects a miss then, followed by a hit on the next read. Second, it issues a write hit to a resident line together with a middle fill beat of another line, and then reads back both lines in full to confirm that each write landed. The same sweep-and-readback method judges eviction in a full bank: exactly one of the 65 competing lines must miss.

// File: rtl/segcam_cache.sv
module segcam_cache #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int BANK_BITS  = 2,
  parameter int ENTRY_BITS = 6,
  parameter int WORD_BITS  = 2,
  localparam int BE_W      = DATA_W / 8,
  localparam int BYTE_BITS = $clog2(BE_W),
  localparam int OFF_W     = BYTE_BITS + WORD_BITS,
  localparam int TAG_LSB   = OFF_W + BANK_BITS,
  localparam int TAG_W     = ADDR_W - TAG_LSB,
  localparam int BANKS     = 1 << BANK_BITS,
  localparam int WAYS      = 1 << ENTRY_BITS,
  localparam int LINES     = BANKS * WAYS,
  localparam int LINE_W    = BANK_BITS + ENTRY_BITS,
  localparam int RAM_W     = LINE_W + WORD_BITS,
  localparam int RAM_DEPTH = 1 << RAM_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  req_valid,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [BE_W-1:0]       req_be,
  output logic [BANKS-1:0]      bank_cmp_en,
  output logic                  resp_valid,
  output logic                  resp_hit,
  output logic                  resp_alloc,
  output logic [DATA_W-1:0]     resp_rdata,
  output logic                  mem_wr_valid,
  output logic [ADDR_W-1:0]     mem_wr_addr,
  output logic [DATA_W-1:0]     mem_wr_data,
  output logic [BE_W-1:0]       mem_wr_be,
  input  logic                  fill_valid,
  input  logic [ADDR_W-1:OFF_W] fill_line,
  input  logic [WORD_BITS-1:0]  fill_word,
  input  logic [DATA_W-1:0]     fill_data
);

  logic [TAG_W-1:0]      tag_q [LINES];
  logic [LINES-1:0]      valid_q;
  logic [DATA_W-1:0]     ram_q [RAM_DEPTH];
  logic [ENTRY_BITS-1:0] lfsr_q;
  logic                  fill_act_q;
  logic [BANK_BITS-1:0]  fill_bank_q;
  logic [ENTRY_BITS-1:0] fill_idx_q;

  wire [BANK_BITS-1:0] req_bank = req_addr[TAG_LSB-1:OFF_W];
  wire [WORD_BITS-1:0] req_word = req_addr[OFF_W-1:BYTE_BITS];
  wire [TAG_W-1:0]     req_tag  = req_addr[ADDR_W-1:TAG_LSB];
  wire [BANK_BITS-1:0] new_bank = fill_line[TAG_LSB-1:OFF_W];
  wire [TAG_W-1:0]     new_tag  = fill_line[ADDR_W-1:TAG_LSB];

  logic [LINES-1:0] match;
  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bank_cmp_en[b] = req_valid && (req_bank == BANK_BITS'(b));
    for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign match[b*WAYS+w] = bank_cmp_en[b] && valid_q[b*WAYS+w] &&
                               (tag_q[b*WAYS+w] == req_tag);
    end
  end

  wire [WAYS-1:0] sel_match = match[req_bank*WAYS +: WAYS];
  wire            hit       = |match;

  logic [ENTRY_BITS-1:0] hit_idx;
  always_comb begin
    hit_idx = '0;
    for (int w = 0; w < WAYS; w++)
      if (sel_match[w]) hit_idx = hit_idx | ENTRY_BITS'(w);
  end

  wire [WAYS-1:0] new_bank_valid = valid_q[new_bank*WAYS +: WAYS];
  logic [ENTRY_BITS-1:0] victim;
  always_comb begin
    victim = lfsr_q;
    for (int w = WAYS - 1; w >= 0; w--)
      if (!new_bank_valid[w]) victim = ENTRY_BITS'(w);
  end

  wire                  fill_start = fill_valid && (fill_word == '0);
  wire                  fill_go    = fill_valid && (fill_start || fill_act_q);
  wire                  fill_last  = fill_valid && fill_act_q && (fill_word == '1);
  wire [BANK_BITS-1:0]  fill_bk    = fill_start ? new_bank : fill_bank_q;
  wire [ENTRY_BITS-1:0] fill_idx   = fill_start ? victim : fill_idx_q;
  wire [LINE_W-1:0]     fill_ln    = {fill_bk, fill_idx};
  wire [RAM_W-1:0]      fill_ram   = {fill_bk, fill_idx, fill_word};
  wire [RAM_W-1:0]      hit_ram    = {req_bank, hit_idx, req_word};
  wire                  wr_hit     = req_valid && req_write && hit;
  wire                  lfsr_fb    = lfsr_q[ENTRY_BITS-1] ^ lfsr_q[ENTRY_BITS-2];

  always_ff @(posedge clk) begin
    if (wr_hit)
      for (int i = 0; i < BE_W; i++)
        if (req_be[i]) ram_q[hit_ram][8*i +: 8] <= req_wdata[8*i +: 8];
    if (fill_go) ram_q[fill_ram] <= fill_data;
    if (fill_start) tag_q[fill_ln] <= new_tag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q     <= '0;
      lfsr_q      <= ENTRY_BITS'(1);
      fill_act_q  <= 1'b0;
      fill_bank_q <= '0;
      fill_idx_q  <= '0;
    end else begin
      lfsr_q <= {lfsr_q[ENTRY_BITS-2:0], lfsr_fb};
      if (flush) begin
        valid_q    <= '0;
        fill_act_q <= 1'b0;
      end else if (fill_start) begin
        valid_q[fill_ln] <= 1'b0;
        fill_act_q       <= 1'b1;
        fill_bank_q      <= new_bank;
        fill_idx_q       <= victim;
      end else if (fill_last) begin
        valid_q[fill_ln] <= 1'b1;
        fill_act_q       <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid   <= 1'b0;
      resp_hit     <= 1'b0;
      resp_alloc   <= 1'b0;
      resp_rdata   <= '0;
      mem_wr_valid <= 1'b0;
      mem_wr_addr  <= '0;
      mem_wr_data  <= '0;
      mem_wr_be    <= '0;
    end else begin
      resp_valid   <= req_valid;
      resp_hit     <= req_valid && hit;
      resp_alloc   <= req_valid && !req_write && !hit;
      resp_rdata   <= (req_valid && !req_write && hit) ? ram_q[hit_ram] : '0;
      mem_wr_valid <= req_valid && req_write;
      mem_wr_addr  <= (req_valid && req_write) ? req_addr : '0;
      mem_wr_data  <= (req_valid && req_write) ? req_wdata : '0;
      mem_wr_be    <= (req_valid && req_write) ? req_be : '0;
    end
  end

  AST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_cmp_en)); // R2
  AST_BANK_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $countones(bank_cmp_en) == 1); // R2
  AST_UNIQUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match)); // R3
  AST_WRITE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |=> mem_wr_valid && !resp_alloc); // R5
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> valid_q == '0); // R9
  AST_VALID_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q & ~$past(valid_q)) != '0 |-> $past(fill_valid && fill_word == '1)); // R7

endmodule

// File: tb/segcam_cache_bench.sv
`timescale 1ns/1ps
module segcam_cache_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic [3:0]  bank_cmp_en;
  logic        resp_valid, resp_hit, resp_alloc;
  logic [31:0] resp_rdata;
  logic        mem_wr_valid;
  logic [31:0] mem_wr_addr, mem_wr_data;
  logic [3:0]  mem_wr_be;
  logic        fill_valid = 1'b0;
  logic [31:4] fill_line = '0;
  logic [1:0]  fill_word = '0;
  logic [31:0] fill_data = '0;

  int nchk = 0, nfail = 0, cyc = 0;

  segcam_cache u_segcam_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .bank_cmp_en(bank_cmp_en),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_alloc(resp_alloc),
    .resp_rdata(resp_rdata), .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_be(mem_wr_be), .fill_valid(fill_valid),
    .fill_line(fill_line), .fill_word(fill_word), .fill_data(fill_data));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      nfail = nfail + 1;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  function automatic [31:0] pat(input [31:0] a, input int w);
    return {a[31:4], w[1:0], 2'b00} ^ 32'h5A3C_96E1;
  endfunction

  task automatic chk(input bit ok, input string rq, input [31:0] act, input [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic rd(input [31:0] a);
    @(negedge clk); req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk); req_valid = 0;
  endtask

  task automatic wr(input [31:0] a, input [31:0] d, input [3:0] be);
    @(negedge clk); req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk); req_valid = 0; req_write = 0;
  endtask

  task automatic beat(input [31:0] a, input int w);
    fill_valid = 1; fill_line = a[31:4]; fill_word = w[1:0]; fill_data = pat(a, w);
  endtask

  task automatic do_fill(input [31:0] a);
    for (int w = 0; w < 4; w++) begin
      @(negedge clk); beat(a, w);
    end
    @(negedge clk); fill_valid = 0;
  endtask

  task automatic chk_hit(input [31:0] a, input int w, input string rq);
    rd(a | (w << 2));
    chk(resp_valid && resp_hit, rq, {31'b0, resp_hit}, 32'd1);
    chk(resp_rdata == pat(a, w), rq, resp_rdata, pat(a, w));
  endtask

  task automatic chk_miss(input [31:0] a, input string rq);
    rd(a);
    chk(!resp_hit && resp_alloc, rq, {30'b0, resp_hit, resp_alloc}, 32'd1);
  endtask

  localparam logic [31:0] LA = 32'h0001_2350;
  localparam logic [31:0] LB = 32'h0002_4560;
  localparam logic [31:0] LC = 32'h0003_0070;
  localparam logic [31:0] LD = 32'h0004_0010;

  initial begin
    logic [31:0] e;
    int hits;
    repeat (4) @(negedge clk);
    rst_n = 1;
    chk(!resp_valid && !mem_wr_valid, "R4 reset outputs", {30'b0, resp_valid, mem_wr_valid}, 0);
    chk_miss(32'h0000_0040, "R4 miss after reset");

    for (int b = 0; b < 4; b++)
      for (int v = 0; v < 2; v++) begin
        @(negedge clk); req_valid = v[0]; req_write = 0; req_addr = 32'h000A_BC00 | (b << 4);
        #1 chk(bank_cmp_en == (v ? 4'(1 << b) : 4'h0), "R2 bank enable", {28'b0, bank_cmp_en},
               v ? (1 << b) : 0);
        @(negedge clk); req_valid = 0;
      end

    for (int w = 0; w < 3; w++) begin
      @(negedge clk); beat(LA, w);
    end
    @(negedge clk); fill_valid = 0;
    chk_miss(LA, "R7 partial line misses");
    @(negedge clk); beat(LA, 3); req_valid = 1; req_write = 0; req_addr = LA | 32'hC;
    @(negedge clk); fill_valid = 0; req_valid = 0;
    chk(!resp_hit, "R7 lookup with last beat misses", {31'b0, resp_hit}, 0);
    chk_hit(LA, 3, "R7 hit after last beat");
    rd(LA | 32'hB);
    chk(resp_hit && resp_rdata == pat(LA, 2), "R1 byte offset ignored", resp_rdata, pat(LA, 2));

    @(negedge clk); beat(LB, 0);
    @(negedge clk); beat(LB, 1);
    req_valid = 1; req_write = 1; req_addr = LA; req_wdata = 32'hCAFE_F00D; req_be = 4'hF;
    @(negedge clk); req_valid = 0; req_write = 0; beat(LB, 2);
    chk(mem_wr_valid && mem_wr_addr == LA, "R10 R5 write-through during fill", mem_wr_addr, LA);
    @(negedge clk); beat(LB, 3);
    @(negedge clk); fill_valid = 0;
    rd(LA);
    chk(resp_hit && resp_rdata == 32'hCAFE_F00D, "R10 write hit kept", resp_rdata, 32'hCAFE_F00D);
    for (int w = 0; w < 4; w++) chk_hit(LB, w, "R10 concurrent fill line");

    wr(LA | 32'h4, 32'h1122_3344, 4'b0101);
    chk(mem_wr_valid && mem_wr_be == 4'b0101 && mem_wr_data == 32'h1122_3344 && resp_hit,
        "R5 write hit copied out", mem_wr_data, 32'h1122_3344);
    e = (pat(LA, 1) & 32'hFF00_FF00) | (32'h1122_3344 & 32'h00FF_00FF);
    rd(LA | 32'h4);
    chk(resp_hit && resp_rdata == e, "R6 byte enable merge", resp_rdata, e);

    wr(LC, 32'hDEAD_BEEF, 4'hF);
    chk(mem_wr_valid && mem_wr_addr == LC && !resp_hit && !resp_alloc,
        "R5 write miss", mem_wr_addr, LC);
    chk_miss(LC, "R5 write miss no allocate");

    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    chk_miss(LA, "R9 flush clears A");
    chk_miss(LB, "R9 flush clears B");

    for (int b = 0; b < 4; b++)
      for (int t = 1; t <= 64; t++) do_fill((t << 6) | (b << 4));
    for (int b = 0; b < 4; b++)
      for (int t = 1; t <= 64; t++)
        for (int w = 0; w < 4; w++) chk_hit((t << 6) | (b << 4), w, "R11 R3 full cache");

    do_fill(32'd200 << 6);
    for (int w = 0; w < 4; w++) chk_hit(32'd200 << 6, w, "R8 new line resident");
    hits = 0;
    for (int t = 1; t <= 64; t++) begin
      rd(t << 6);
      if (resp_hit) hits++;
    end
    chk(hits == 63, "R8 exactly one eviction", hits, 63);
    hits = 0;
    for (int t = 1; t <= 64; t++) begin
      rd((t << 6) | 32'h10);
      if (resp_hit) hits++;
    end
    chk(hits == 64, "R8 other bank untouched", hits, 64);

    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    @(negedge clk); beat(LD, 0);
    @(negedge clk); beat(LD, 1);
    @(negedge clk); fill_valid = 0; flush = 1;
    @(negedge clk); flush = 0; beat(LD, 2);
    @(negedge clk); beat(LD, 3);
    @(negedge clk); fill_valid = 0;
    chk_miss(LD, "R9 aborted fill stays invalid");

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule